// File: doc/BRIEF.md
# Audio Serial Transmitter with Master Timing

This block takes left and right samples in parallel and shifts them out one bit at a time on the data line of a three-wire audio serial port. One control bit decides who owns the port clocks. With the bit set, the block makes the bit clock and the frame clock from the system clock, using two divide settings. With the bit clear, it follows a bit clock and a frame clock driven from outside.

The framing is chosen at run time. There are four layouts: left aligned, right aligned, the standard one-bit-delayed layout, and a pulse-framed layout that packs both channels back to back. The pulse-framed layout has two sub-timings. The word length can be 16, 20, 24 or 32 bits. Controls can invert the frame-clock level, invert the bit clock, and swap the two channels.

A producer offers a sample pair over a valid/ready handshake. The pair is held until the next frame starts. If no new pair has arrived by then, the previous pair is sent again.

Top module: `aud_ser_tx`

## Requirements
- R1: With `master_en`=1 the block drives `bclk_out` and `lrclk_out` and raises `clk_drive`. With `master_en`=0, `clk_drive`, `bclk_out` and `lrclk_out` stay low, and the block times its data from `bclk_in` and `lrclk_in`.
- R2: In master mode the bit clock has a period of 2·`bclk_div` system clocks. A setting of 0 acts as 1.
- R3: In master mode a frame lasts `frame_div` bit clocks. The frame clock changes only at falling edges of the effective bit clock. Outside format 11 it is high for exactly half of the frame. In format 11 it is a pulse one bit clock wide at the start of the frame.
- R4: Format 01 (left aligned): the MSB of each channel word is valid at the first rising edge after the frame clock changes.
- R5: Format 10: the MSB is valid at the second rising edge after the frame clock changes. The left channel is sent while the frame clock is low (`lrp`=0).
- R6: Format 00 (right aligned): the LSB is valid at the last rising edge of each half-frame. The half length is measured from the frame clock itself. Word code 11 is sent as 24 bits in this format.
- R7: Format 11: the left word and then the right word follow the frame pulse back to back. The left MSB is valid at the second rising edge after the pulse rises when `lrp`=0, and at the first rising edge when `lrp`=1.
- R8: Word code 00/01/10/11 selects 16/20/24/32 bits. The bits sent are the top bits of the 32-bit sample, MSB first.
- R9: In formats 00 and 01 the left channel goes out while the frame clock is high. Setting `lrp` inverts the frame-clock level for formats 00, 01 and 10.
- R10: `bclk_inv` inverts the pin bit clock in both modes. Data keeps the same relation to the effective (un-inverted) clock.
- R11: With `swap`=1 at frame start, the right sample goes out in the left slot and the left sample goes out in the right slot.
- R12: `smp_ready` falls in the cycle after an accepted pair. It stays low until the next frame start loads that pair. When no pair is waiting, the last pair repeats every frame.
- R13: Outside the bit positions of a word, the data line is low.
- R14: `sdata` changes only while the effective bit clock is low, right after its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1: block drives the port clocks; 0: follows them |
| fmt | input | 2 | Framing: 00 right aligned, 01 left aligned, 10 delayed-by-one, 11 pulse framed |
| wlen | input | 2 | Word length code 00/01/10/11 = 16/20/24/32 bits |
| lrp | input | 1 | Frame-clock level invert; sub-timing select in format 11 |
| bclk_inv | input | 1 | Bit-clock invert |
| swap | input | 1 | Channel swap |
| bclk_div | input | DIV_W | System clocks per half bit-clock period (master) |
| frame_div | input | FR_W | Bit clocks per frame (master) |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Block can take a pair |
| smp_left | input | SAMPLE_W | Left sample, MSB aligned |
| smp_right | input | SAMPLE_W | Right sample, MSB aligned |
| bclk_in | input | 1 | External bit clock (slave) |
| lrclk_in | input | 1 | External frame clock (slave) |
| bclk_out | output | 1 | Generated bit clock (master) |
| lrclk_out | output | 1 | Generated frame clock (master) |
| clk_drive | output | 1 | Output enable for the clock pins |
| sdata | output | 1 | Serial data |

## Verification
In master mode, `sdata` is updated one system clock after the bit-clock pin falls. In slave mode the update comes after the synchronizer stages plus two registers. In both modes the value is due at the next rising edge of the effective bit clock. The bench behaves as a receiver: it polls at the falling system-clock edge, spots rising edges of the effective clock, and rebuilds the words from the frame-clock timing of each format. This keeps every sample half a bit clock after the data update and clear of the clock edge. `smp_ready` is checked at the first falling system-clock edge after acceptance. Loaded samples are judged only after several whole frames, so a mode change partway through a frame never reaches a check.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   typedef enum logic [1:0] {
      FMT_RJ  = 2'b00,
      FMT_LJ  = 2'b01,
      FMT_I2S = 2'b10,
      FMT_DSP = 2'b11
   } fmt_e;

   // Number of bits per channel word; right aligned framing tops out at 24.
   function automatic logic [5:0] word_bits(input logic [1:0] wlen, input fmt_e fmt);
      case (wlen)
         2'b00:   word_bits = 6'd16;
         2'b01:   word_bits = 6'd20;
         2'b10:   word_bits = 6'd24;
         default: word_bits = (fmt == FMT_RJ) ? 6'd24 : 6'd32;
      endcase
   endfunction

   // Frame clock level that marks the left half (non pulse formats).
   function automatic logic left_level(input fmt_e fmt, input logic lrp);
      left_level = (fmt == FMT_I2S) ? lrp : ~lrp;
   endfunction

endpackage

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen
   import aud_tx_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int FR_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  fmt_e             fmt,
   input  logic             lrp,
   input  logic [DIV_W-1:0] bclk_div,
   input  logic [FR_W-1:0]  frame_div,
   output logic             bclk_q,
   output logic             lr_q
);

   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] div_lim;
   logic [FR_W-1:0]  bit_cnt;
   logic [FR_W-1:0]  bit_nxt;
   logic [FR_W-1:0]  half_pt;
   logic             tick;
   logic             lvl_left;

   assign div_lim  = (bclk_div == '0) ? DIV_W'(1) : bclk_div;
   assign tick     = (div_cnt >= div_lim - 1'b1);
   assign half_pt  = frame_div >> 1;
   assign bit_nxt  = (bit_cnt >= frame_div - 1'b1) ? '0 : bit_cnt + 1'b1;
   assign lvl_left = left_level(fmt, lrp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         bit_cnt <= '1;
         bclk_q  <= 1'b0;
         lr_q    <= 1'b0;
      end else if (!run) begin
         div_cnt <= '0;
         bit_cnt <= '1;
         bclk_q  <= 1'b0;
         lr_q    <= 1'b0;
      end else if (tick) begin
         div_cnt <= '0;
         bclk_q  <= ~bclk_q;
         if (bclk_q) begin
            bit_cnt <= bit_nxt;
            if (fmt == FMT_DSP) lr_q <= (bit_nxt == '0);
            else                lr_q <= (bit_nxt < half_pt) ? lvl_left : ~lvl_left;
         end
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   // R3: the frame clock only moves together with a bit-clock fall
   p_lr_on_fall_r3 : assert property (@(posedge clk) disable iff (!rst_n || !run)
      (lr_q != $past(lr_q)) |-> ($past(bclk_q) && !bclk_q));

   // R3: in pulse framing the pulse ends at the following fall
   p_dsp_pulse_r3 : assert property (@(posedge clk) disable iff (!rst_n || !run)
      (fmt == FMT_DSP && $past(fmt) == FMT_DSP && frame_div > FR_W'(1) &&
       $past(lr_q) && $past(bclk_q) && !bclk_q) |-> !lr_q);

endmodule

// File: rtl/aud_tx_edge.sv
module aud_tx_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic master_en,
   input  logic bclk_inv,
   input  logic gen_bclk,
   input  logic gen_lr,
   input  logic bclk_pin,
   input  logic lr_pin,
   output logic fall_evt,
   output logic lr_lvl
);

   logic [SYNC_STAGES-1:0] b_sh;
   logic [SYNC_STAGES-1:0] l_sh;
   logic                   eff_b;
   logic                   eff_prev;

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b_sh <= '0;
            l_sh <= '0;
         end else begin
            b_sh <= bclk_pin;
            l_sh <= lr_pin;
         end
      end
   end else begin : g_sync_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b_sh <= '0;
            l_sh <= '0;
         end else begin
            b_sh <= {b_sh[SYNC_STAGES-2:0], bclk_pin};
            l_sh <= {l_sh[SYNC_STAGES-2:0], lr_pin};
         end
      end
   end

   assign eff_b  = master_en ? gen_bclk : (b_sh[SYNC_STAGES-1] ^ bclk_inv);
   assign lr_lvl = master_en ? gen_lr : l_sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eff_prev <= 1'b0;
      else        eff_prev <= eff_b;
   end

   assign fall_evt = eff_prev & ~eff_b;

endmodule

// File: rtl/aud_tx_ser.sv
module aud_tx_ser
   import aud_tx_pkg::*;
#(
   parameter int SW    = 32,
   parameter int POS_W = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall_evt,
   input  logic          lr_lvl,
   input  fmt_e          fmt,
   input  logic [1:0]    wlen,
   input  logic          lrp,
   input  logic          swap,
   input  logic          valid,
   input  logic [SW-1:0] left,
   input  logic [SW-1:0] right,
   output logic          ready,
   output logic          sdata
);

   logic             is_dsp, lvl_left, lr_evt;
   logic             half_start, frame_start, seg_start;
   logic [POS_W-1:0] bpos, pos, half_len, hl, off, wlb, pos_rel, idx;
   logic [SW-1:0]    act_l, act_r, pend_l, pend_r, cur_l, cur_r, word, shifted;
   logic             pend_full, in_word, bit_v;

   assign is_dsp      = (fmt == FMT_DSP);
   assign lvl_left    = left_level(fmt, lrp);
   assign wlb         = POS_W'(word_bits(wlen, fmt));
   assign half_start  = !is_dsp && (lr_lvl != lr_evt);
   assign frame_start = is_dsp ? (lr_lvl && !lr_evt) : (half_start && (lr_lvl == lvl_left));
   assign seg_start   = is_dsp ? frame_start : half_start;
   assign pos         = seg_start ? '0 : ((&bpos) ? bpos : bpos + 1'b1);
   assign hl          = half_start ? bpos + 1'b1 : half_len;
   assign ready       = !pend_full;

   // The pair loaded at a frame start is already visible to that frame's first bit.
   assign cur_l = (frame_start && pend_full) ? (swap ? pend_r : pend_l) : act_l;
   assign cur_r = (frame_start && pend_full) ? (swap ? pend_l : pend_r) : act_r;

   always_comb begin
      case (fmt)
         FMT_LJ:  off = '0;
         FMT_I2S: off = POS_W'(1);
         FMT_RJ:  off = (hl > wlb) ? hl - wlb : '0;
         default: off = lrp ? '0 : POS_W'(1);
      endcase
   end

   assign pos_rel = pos - off;

   always_comb begin
      in_word = 1'b0;
      word    = cur_l;
      idx     = pos_rel;
      if (pos >= off) begin
         if (is_dsp) begin
            if (pos_rel < wlb) begin
               in_word = 1'b1;
            end else if (pos_rel < (wlb << 1)) begin
               in_word = 1'b1;
               word    = cur_r;
               idx     = pos_rel - wlb;
            end
         end else if (pos_rel < wlb) begin
            in_word = 1'b1;
            word    = (lr_lvl == lvl_left) ? cur_l : cur_r;
         end
      end
      shifted = word << idx;
      bit_v   = in_word & shifted[SW-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_evt    <= 1'b0;
         bpos      <= '0;
         half_len  <= '0;
         sdata     <= 1'b0;
         act_l     <= '0;
         act_r     <= '0;
         pend_l    <= '0;
         pend_r    <= '0;
         pend_full <= 1'b0;
      end else begin
         if (valid && !pend_full) begin
            pend_l    <= left;
            pend_r    <= right;
            pend_full <= 1'b1;
         end
         if (fall_evt) begin
            lr_evt <= lr_lvl;
            bpos   <= pos;
            sdata  <= bit_v;
            if (half_start) half_len <= bpos + 1'b1;
            if (frame_start && pend_full) begin
               act_l     <= cur_l;
               act_r     <= cur_r;
               pend_full <= 1'b0;
            end
         end
      end
   end

   // R12: an accepted pair closes the handshake on the next cycle
   p_accept_closes_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready) |=> !ready);

   // R12: a waiting pair is kept until a frame start takes it
   p_pending_kept_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_full && !(fall_evt && frame_start)) |=> pend_full);

   // R14: the data line moves only after a bit-clock fall
   p_data_on_fall_r14 : assert property (@(posedge clk) disable iff (!rst_n)
      (sdata != $past(sdata)) |-> $past(fall_evt));

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
   import aud_tx_pkg::*;
#(
   parameter int SAMPLE_W    = 32,
   parameter int DIV_W       = 8,
   parameter int FR_W        = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                master_en,
   input  logic [1:0]          fmt,
   input  logic [1:0]          wlen,
   input  logic                lrp,
   input  logic                bclk_inv,
   input  logic                swap,
   input  logic [DIV_W-1:0]    bclk_div,
   input  logic [FR_W-1:0]     frame_div,
   input  logic                smp_valid,
   output logic                smp_ready,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                bclk_in,
   input  logic                lrclk_in,
   output logic                bclk_out,
   output logic                lrclk_out,
   output logic                clk_drive,
   output logic                sdata
);

   localparam int POS_W = FR_W + 1;

   if (SAMPLE_W < 32) begin : g_chk_sw
      $error("SAMPLE_W must hold a 32-bit word");
   end
   if (FR_W < 7) begin : g_chk_fr
      $error("FR_W must count at least 64 bit clocks");
   end
   if (SYNC_STAGES < 1) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 1");
   end

   fmt_e fmt_t;
   logic gen_bclk, gen_lr, fall_evt, lr_lvl;

   assign fmt_t = fmt_e'(fmt);

   aud_tx_clkgen #(.DIV_W(DIV_W), .FR_W(FR_W)) u_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (master_en),
      .fmt       (fmt_t),
      .lrp       (lrp),
      .bclk_div  (bclk_div),
      .frame_div (frame_div),
      .bclk_q    (gen_bclk),
      .lr_q      (gen_lr)
   );

   aud_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_en (master_en),
      .bclk_inv  (bclk_inv),
      .gen_bclk  (gen_bclk),
      .gen_lr    (gen_lr),
      .bclk_pin  (bclk_in),
      .lr_pin    (lrclk_in),
      .fall_evt  (fall_evt),
      .lr_lvl    (lr_lvl)
   );

   aud_tx_ser #(.SW(SAMPLE_W), .POS_W(POS_W)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_evt (fall_evt),
      .lr_lvl   (lr_lvl),
      .fmt      (fmt_t),
      .wlen     (wlen),
      .lrp      (lrp),
      .swap     (swap),
      .valid    (smp_valid),
      .left     (smp_left),
      .right    (smp_right),
      .ready    (smp_ready),
      .sdata    (sdata)
   );

   assign bclk_out  = master_en & (gen_bclk ^ bclk_inv);
   assign lrclk_out = master_en & gen_lr;
   assign clk_drive = master_en;

endmodule

// File: tb/test_aud_ser_tx.sv
module test_aud_ser_tx;

   localparam int FR = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_en = 1'b0;
   logic [1:0]  fmt = 2'b01;
   logic [1:0]  wlen = 2'b00;
   logic        lrp = 1'b0, bclk_inv = 1'b0, swap = 1'b0;
   logic [7:0]  bclk_div = 8'd2;
   logic [8:0]  frame_div = 9'd80;
   logic        smp_valid = 1'b0;
   logic [31:0] smp_left = '0, smp_right = '0;
   logic        smp_ready, bclk_in, bclk_out, lrclk_out, clk_drive, sdata;
   logic        lrclk_in = 1'b0;

   int tests = 0, fails = 0;

   always #10 clk = ~clk;

   aud_ser_tx i_aud_ser_tx (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .fmt(fmt), .wlen(wlen),
      .lrp(lrp), .bclk_inv(bclk_inv), .swap(swap), .bclk_div(bclk_div),
      .frame_div(frame_div), .smp_valid(smp_valid), .smp_ready(smp_ready),
      .smp_left(smp_left), .smp_right(smp_right), .bclk_in(bclk_in),
      .lrclk_in(lrclk_in), .bclk_out(bclk_out), .lrclk_out(lrclk_out),
      .clk_drive(clk_drive), .sdata(sdata));

   function automatic int bits_of(input logic [1:0] f, input logic [1:0] w);
      case (w)
         2'b00:   return 16;
         2'b01:   return 20;
         2'b10:   return 24;
         default: return (f == 2'b00) ? 24 : 32;
      endcase
   endfunction

   function automatic logic left_lvl(input logic [1:0] f, input logic p);
      return (f == 2'b10) ? p : ~p;
   endfunction

   // External clock source for slave runs: half bit period of 4 system clocks
   logic s_eff = 1'b0;
   int   s_div = 0, s_bc = FR - 1;
   assign bclk_in = s_eff ^ bclk_inv;
   always @(negedge clk) begin
      if (s_div == 3) begin
         s_div <= 0;
         s_eff <= ~s_eff;
         if (s_eff) begin
            int nb;
            nb = (s_bc == FR - 1) ? 0 : s_bc + 1;
            s_bc <= nb;
            if (fmt == 2'b11) lrclk_in <= (nb == 0);
            else lrclk_in <= (nb < FR / 2) ? left_lvl(fmt, lrp) : ~left_lvl(fmt, lrp);
         end
      end else begin
         s_div <= s_div + 1;
      end
   end

   // Receiver model working from the requirements
   logic        rx_e = 1'b0, rx_l = 1'b0, rx_sd = 1'b0;
   int          rx_cnt = 0, rx_lcnt = 0, rx_zerr = 0, rx_hichg = 0;
   logic [31:0] accl = '0, accr = '0, rx_left = '0, rx_right = '0;
   always @(negedge clk) begin
      logic e, l;
      int   wb, off, slot, idx;
      e = (master_en ? bclk_out : bclk_in) ^ bclk_inv;
      l = master_en ? lrclk_out : lrclk_in;
      if (sdata != rx_sd && e) rx_hichg++;
      rx_sd = sdata;
      if (e && !rx_e) begin
         if (fmt == 2'b11) rx_cnt = (l && !rx_l) ? 1 : ((rx_cnt < 1000) ? rx_cnt + 1 : rx_cnt);
         else rx_cnt = (l != rx_l) ? 1 : ((rx_cnt < 1000) ? rx_cnt + 1 : rx_cnt);
         rx_l = l;
         wb = bits_of(fmt, wlen);
         slot = -1;
         idx = 0;
         if (fmt == 2'b11) begin
            off = lrp ? 1 : 2;
            if (rx_cnt >= off && rx_cnt < off + wb) begin slot = 0; idx = rx_cnt - off; end
            else if (rx_cnt >= off + wb && rx_cnt < off + 2 * wb) begin slot = 1; idx = rx_cnt - off - wb; end
         end else begin
            off = (fmt == 2'b01) ? 1 : (fmt == 2'b10) ? 2 : FR / 2 - wb + 1;
            if (rx_cnt >= off && rx_cnt < off + wb) begin
               slot = (l == left_lvl(fmt, lrp)) ? 0 : 1;
               idx = rx_cnt - off;
            end
         end
         if (slot == 0) begin
            accl[31-idx] = sdata;
            if (idx == wb - 1) begin rx_left = accl; accl = '0; rx_lcnt++; end
         end else if (slot == 1) begin
            accr[31-idx] = sdata;
            if (idx == wb - 1) begin rx_right = accr; accr = '0; end
         end else if (sdata) begin
            rx_zerr++;
         end
      end
      rx_e = e;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_pair(input logic [31:0] l, input logic [31:0] r);
      @(negedge clk);
      smp_left = l; smp_right = r; smp_valid = 1'b1;
      while (!smp_ready) @(negedge clk);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      repeat (n * FR * (master_en ? 2 * int'(bclk_div) : 8)) @(negedge clk);
   endtask

   task automatic run_cfg(input bit ms, input logic [1:0] f, input logic [1:0] w, input bit p,
                          input bit inv, input bit sw, input logic [31:0] l, input logic [31:0] r,
                          input string req);
      int z0, h0, c0, wb;
      logic [31:0] m, el, er;
      @(negedge clk);
      master_en = ms; fmt = f; wlen = w; lrp = p; bclk_inv = inv; swap = sw;
      bclk_div = 8'd2; frame_div = 9'(FR);
      wait_frames(2);
      send_pair(l, r);
      wait_frames(4);
      z0 = rx_zerr; h0 = rx_hichg; c0 = rx_lcnt;
      wait_frames(3);
      wb = bits_of(f, w);
      m = 32'hFFFF_FFFF << (32 - wb);
      el = (sw ? r : l) & m;
      er = (sw ? l : r) & m;
      check(rx_left == el, {req, " left word"}, rx_left, el);
      check(rx_right == er, {req, " right word"}, rx_right, er);
      check(rx_lcnt - c0 >= 2, "R12 pair repeats each frame", rx_lcnt - c0, 2);
      check(rx_zerr == z0, "R13 idle bits low", rx_zerr - z0, 0);
      check(rx_hichg == h0, "R14 data moves while clock low", rx_hichg - h0, 0);
   endtask

   task automatic t_reset;
      check(sdata == 1'b0, "R13 sdata low at reset", sdata, 0);
      check(smp_ready == 1'b1, "R12 ready at reset", smp_ready, 1);
      check(clk_drive == 1'b0 && bclk_out == 1'b0 && lrclk_out == 1'b0,
            "R1 pins quiet in slave", {clk_drive, bclk_out, lrclk_out}, 0);
   endtask

   task automatic t_bclk_period(input logic [7:0] dv, input int exp);
      logic pv; int n;
      @(negedge clk);
      master_en = 1'b1; bclk_inv = 1'b0; bclk_div = dv;
      repeat (20) @(negedge clk);
      pv = bclk_out;
      while (!(bclk_out && !pv)) begin pv = bclk_out; @(negedge clk); end
      n = 0; pv = bclk_out;
      do begin @(negedge clk); n++; end while (!(bclk_out && !pv) && ((pv = bclk_out) || 1'b1));
      check(n == exp, "R2 bit clock period", n, exp);
      check(clk_drive == 1'b1, "R1 clock pins driven in master", clk_drive, 1);
   endtask

   task automatic t_frame(input logic [1:0] f, input int exp_hi, input string req);
      logic pb, pl; int started, cnt, hi;
      @(negedge clk);
      master_en = 1'b1; fmt = f; lrp = 1'b0; bclk_inv = 1'b0; bclk_div = 8'd2; frame_div = 9'(FR);
      wait_frames(2);
      started = 0; cnt = 0; hi = 0; pb = bclk_out; pl = lrclk_out;
      while (started < 2) begin
         @(negedge clk);
         if (bclk_out && !pb) begin
            if (lrclk_out && !pl) begin
               started++;
               if (started == 1) begin cnt = 0; hi = 0; end
            end
            if (started == 1) begin cnt++; if (lrclk_out) hi++; end
            pl = lrclk_out;
         end
         pb = bclk_out;
      end
      check(cnt == FR, {req, " frame length"}, cnt, FR);
      check(hi == exp_hi, {req, " frame clock high time"}, hi, exp_hi);
   endtask

   task automatic t_handshake;
      @(negedge clk);
      master_en = 1'b1; fmt = 2'b01; wlen = 2'b00; lrp = 1'b0; bclk_inv = 1'b0; swap = 1'b0;
      wait_frames(2);
      send_pair(32'h1111_0000, 32'h2222_0000);
      check(smp_ready == 1'b0, "R12 ready drops after accept", smp_ready, 0);
      send_pair(32'h3C3C_0000, 32'h5A5A_0000);
      check(smp_ready == 1'b0, "R12 second pair waits for frame start", smp_ready, 0);
      wait_frames(4);
      check(rx_left == 32'h3C3C_0000 && rx_right == 32'h5A5A_0000, "R12 latest pair sent",
            {rx_left, rx_right}, {32'h3C3C_0000, 32'h5A5A_0000});
      check(smp_ready == 1'b1, "R12 ready back after load", smp_ready, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_bclk_period(8'd2, 4);
      t_bclk_period(8'd3, 6);
      t_bclk_period(8'd0, 2);
      t_frame(2'b01, FR / 2, "R3 left aligned");
      t_frame(2'b11, 1, "R3 pulse framed");
      run_cfg(1, 2'b01, 2'b10, 0, 0, 0, 32'hA5C3_9E17, 32'h1234_5678, "R4 R8 left aligned 24");
      run_cfg(1, 2'b10, 2'b00, 0, 0, 0, 32'hBEEF_1234, 32'h8001_FFFF, "R5 standard 16");
      run_cfg(1, 2'b10, 2'b01, 1, 0, 0, 32'h0F0F_F0F0, 32'hC001_D00D, "R9 standard 20 inverted level");
      run_cfg(1, 2'b00, 2'b01, 0, 0, 0, 32'h9876_5432, 32'h7FFF_0001, "R6 right aligned 20");
      run_cfg(1, 2'b00, 2'b11, 1, 0, 0, 32'hDEAD_BEEF, 32'h0123_4567, "R6 R9 right aligned code 11");
      run_cfg(1, 2'b11, 2'b11, 0, 0, 0, 32'hCAFE_F00D, 32'h8000_0001, "R7 pulse sub-timing A 32");
      run_cfg(1, 2'b11, 2'b00, 1, 0, 0, 32'h4321_AAAA, 32'hF00F_5555, "R7 pulse sub-timing B 16");
      run_cfg(1, 2'b01, 2'b11, 0, 1, 0, 32'h8765_4321, 32'hFEDC_BA98, "R10 R8 inverted clock 32");
      run_cfg(1, 2'b01, 2'b10, 0, 0, 1, 32'hAAAA_5555, 32'h3333_CCCC, "R11 channel swap");
      run_cfg(0, 2'b10, 2'b10, 0, 0, 0, 32'h6B6B_1C1C, 32'h9494_E3E3, "R1 slave standard 24");
      check(clk_drive == 1'b0 && bclk_out == 1'b0, "R1 slave leaves pins", {clk_drive, bclk_out}, 0);
      run_cfg(0, 2'b11, 2'b01, 1, 1, 0, 32'h1357_9BDF, 32'h2468_ACE0, "R1 R10 slave pulse B");
      t_handshake();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule